// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block holds the interrupt control state of a small 8-bit microcontroller core and turns it into request lines for the core's sequencer. Three core event sources each have a sticky flag and an enable bit: a timer overflow, an external edge input and a port-change event. A parameterised group of peripheral sources is also supported. Each peripheral drives a level request and has its own enable bit and priority bit held here.

Two gate bits in the main control register change meaning with a priority-mode bit. With priority mode off, bit 7 is a master gate and bit 6 is an extra gate for the peripheral group. Only `irq_hi` is used and `irq_lo` stays low. With priority mode on, bit 7 gates every high-priority source and bit 6 gates every low-priority source. The external input is always high priority. The timer and port-change sources follow their own priority bits.

A simple register bus with a write strobe, a 2-bit address, write data and combinational read data gives access to four registers. Vector fetch, context save and return from interrupt belong to the core and are not part of this block.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset every register bit reads 0 at all four addresses, and `irq_hi` and `irq_lo` are 0. The port-change flag has no defined reset value; this implementation clears it.
- R2: With priority mode off, `irq_lo` is 0. `irq_hi` is 1 when bit 7 is set and at least one of the following holds: a core source has both its flag and its enable set, or bit 6 is set and a peripheral has both its request and its enable set.
- R3: With priority mode on, `irq_hi` is 1 when bit 7 is set and a high-priority source is active. High-priority sources are the enabled, flagged external input, the timer or port-change source when its priority bit is 1, and any enabled peripheral request whose priority bit is 1.
- R4: With priority mode on, `irq_lo` is 1 when bit 6 is set and a low-priority source is active. Low-priority sources are the enabled, flagged timer or port-change source when its priority bit is 0, and any enabled peripheral request whose priority bit is 0.
- R5: An event pulse on `tmr_ovf_evt`, `ext_edge_evt` or `port_chg_evt` sets its flag on the next clock edge. This happens whatever the value of any enable, global gate or priority bit.
- R6: Hardware never clears a flag. A flag changes only through a bus write to address 0, which may set or clear it.
- R7: When an event and a bus write to address 0 fall in the same cycle, the event's flag ends up 1.
- R8: Address 0 layout, from bit 7 down to bit 0:
  - bit 7: high gate
  - bit 6: peripheral/low gate
  - bit 5: timer enable
  - bit 4: external enable
  - bit 3: port-change enable
  - bit 2: timer flag
  - bit 1: external flag
  - bit 0: port-change flag
- R9: Address 1 layout: bit 0 is priority mode, bit 1 is the timer priority (1 = high), and bit 2 is the port-change priority (1 = high). Bits 7 to 3 read 0.
- R10: Address 2 holds the peripheral enables and address 3 holds the peripheral priorities (1 = high). Peripheral i uses bit i, and bits at or above NPER read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tmr_ovf_evt | input | 1 | Timer overflow event pulse |
| ext_edge_evt | input | 1 | External edge event pulse |
| port_chg_evt | input | 1 | Port-change event pulse |
| periph_req | input | NPER | Peripheral level requests |
| irq_hi | output | 1 | High-priority request (the only request when priority mode is off) |
| irq_lo | output | 1 | Low-priority request |

## Verification
A wrong flag, enable or priority bit shows up on `rd_data` in the cycle after the edge that stored it, as soon as that address is read. It also shows up on the request outputs in that same cycle whenever the source is gated through. A lost event appears the same way: the flag stays 0 and the request that should follow it is missing. Because a reference model of every register is compared with every read and both requests on each cycle, a bad state is caught within one cycle of the first read or gate that exposes it.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef struct packed {
        logic gate_hi;
        logic gate_lo;
        logic tmr_en;
        logic ext_en;
        logic pchg_en;
        logic tmr_flag;
        logic ext_flag;
        logic pchg_flag;
    } ctrl_t;

    typedef struct packed {
        logic pchg_hi;
        logic tmr_hi;
        logic prio_on;
    } mode_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_PEN  = 2'd2;
    localparam logic [1:0] ADDR_PPRI = 2'd3;

endpackage

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
    import irq_gate_pkg::*;
#(
    parameter int NPER = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [7:0]           wr_data,
    input  logic                 tmr_ovf_evt,
    input  logic                 ext_edge_evt,
    input  logic                 port_chg_evt,
    output ctrl_t                ctrl_q,
    output mode_t                mode_q,
    output logic [NPER-1:0]      pen_q,
    output logic [NPER-1:0]      ppri_q
);

    typedef struct packed {
        ctrl_t           ctrl;
        mode_t           mode;
        logic [NPER-1:0] pen;
        logic [NPER-1:0] ppri;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(wr_data);
                ADDR_MODE: st_d.mode = mode_t'(wr_data[2:0]);
                ADDR_PEN:  st_d.pen  = wr_data[NPER-1:0];
                default:   st_d.ppri = wr_data[NPER-1:0];
            endcase
        end
        // event sets come last so they win over a same-cycle clear
        if (tmr_ovf_evt)  st_d.ctrl.tmr_flag  = 1'b1;
        if (ext_edge_evt) st_d.ctrl.ext_flag  = 1'b1;
        if (port_chg_evt) st_d.ctrl.pchg_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;
    assign mode_q = st_q.mode;
    assign pen_q  = st_q.pen;
    assign ppri_q = st_q.ppri;

endmodule

// File: rtl/irq_gate_pmask.sv
module irq_gate_pmask #(
    parameter int NPER = 4
) (
    input  logic [NPER-1:0] req,
    input  logic [NPER-1:0] pen,
    input  logic [NPER-1:0] ppri,
    input  logic            prio_on,
    output logic            any_hi,
    output logic            any_lo
);

    logic [NPER-1:0] hi_v;
    logic [NPER-1:0] lo_v;

    for (genvar i = 0; i < NPER; i++) begin : g_src
        logic live;
        assign live    = req[i] & pen[i];
        assign hi_v[i] = live & (~prio_on | ppri[i]);
        assign lo_v[i] = live & prio_on & ~ppri[i];
    end

    assign any_hi = |hi_v;
    assign any_lo = |lo_v;

endmodule

// File: rtl/irq_gate_arb.sv
module irq_gate_arb
    import irq_gate_pkg::*;
(
    input  ctrl_t ctrl,
    input  mode_t mode,
    input  logic  per_hi,
    input  logic  per_lo,
    output logic  irq_hi,
    output logic  irq_lo
);

    logic t_act, x_act, p_act;
    logic hi_src, lo_src;

    always_comb begin
        t_act = ctrl.tmr_flag  & ctrl.tmr_en;
        x_act = ctrl.ext_flag  & ctrl.ext_en;
        p_act = ctrl.pchg_flag & ctrl.pchg_en;
        if (mode.prio_on) begin
            hi_src = x_act | (t_act & mode.tmr_hi) | (p_act & mode.pchg_hi) | per_hi;
            lo_src = (t_act & ~mode.tmr_hi) | (p_act & ~mode.pchg_hi) | per_lo;
            irq_hi = ctrl.gate_hi & hi_src;
            irq_lo = ctrl.gate_lo & lo_src;
        end else begin
            hi_src = t_act | x_act | p_act | (ctrl.gate_lo & per_hi);
            lo_src = 1'b0;
            irq_hi = ctrl.gate_hi & hi_src;
            irq_lo = 1'b0;
        end
    end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter int NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    input  logic            tmr_ovf_evt,
    input  logic            ext_edge_evt,
    input  logic            port_chg_evt,
    input  logic [NPER-1:0] periph_req,
    output logic            irq_hi,
    output logic            irq_lo
);

    ctrl_t           ctrl_q;
    mode_t           mode_q;
    logic [NPER-1:0] pen_q;
    logic [NPER-1:0] ppri_q;
    logic            per_hi;
    logic            per_lo;

    irq_gate_regs #(.NPER(NPER)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .tmr_ovf_evt  (tmr_ovf_evt),
        .ext_edge_evt (ext_edge_evt),
        .port_chg_evt (port_chg_evt),
        .ctrl_q       (ctrl_q),
        .mode_q       (mode_q),
        .pen_q        (pen_q),
        .ppri_q       (ppri_q)
    );

    irq_gate_pmask #(.NPER(NPER)) u_pmask (
        .req     (periph_req),
        .pen     (pen_q),
        .ppri    (ppri_q),
        .prio_on (mode_q.prio_on),
        .any_hi  (per_hi),
        .any_lo  (per_lo)
    );

    irq_gate_arb u_arb (
        .ctrl   (ctrl_q),
        .mode   (mode_q),
        .per_hi (per_hi),
        .per_lo (per_lo),
        .irq_hi (irq_hi),
        .irq_lo (irq_lo)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_MODE: rd_data[2:0] = mode_q;
            ADDR_PEN:  rd_data[NPER-1:0] = pen_q;
            default:   rd_data[NPER-1:0] = ppri_q;
        endcase
    end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
    import irq_gate_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  wr_en,
    input logic [1:0] addr,
    input logic  tmr_ovf_evt,
    input logic  ext_edge_evt,
    input ctrl_t ctrl_q,
    input mode_t mode_q,
    input logic  irq_hi,
    input logic  irq_lo
);

    a_r2_flat_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.prio_on |-> !irq_lo);

    a_r2_hi_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.gate_hi |-> !irq_hi);

    a_r3_ext_is_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.prio_on && ctrl_q.gate_hi && ctrl_q.ext_en && ctrl_q.ext_flag) |-> irq_hi);

    a_r4_lo_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.prio_on && !ctrl_q.gate_lo) |-> !irq_lo);

    a_r5_tmr_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_evt |=> ctrl_q.tmr_flag);

    a_r7_ext_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge_evt && wr_en && addr == ADDR_CTRL) |=> ctrl_q.ext_flag);

    a_r6_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.tmr_flag && !(wr_en && addr == ADDR_CTRL)) |=> ctrl_q.tmr_flag);

endmodule

bind irq_gate_ctrl irq_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .tmr_ovf_evt  (tmr_ovf_evt),
    .ext_edge_evt (ext_edge_evt),
    .ctrl_q       (ctrl_q),
    .mode_q       (mode_q),
    .irq_hi       (irq_hi),
    .irq_lo       (irq_lo)
);

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          tmr_ovf_evt = 1'b0;
    logic          ext_edge_evt = 1'b0;
    logic          port_chg_evt = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic          irq_hi;
    logic          irq_lo;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]    m_ctrl = '0;
    logic [2:0]    m_mode = '0;
    logic [NP-1:0] m_pen = '0;
    logic [NP-1:0] m_ppri = '0;

    always #2.5 clk = ~clk;

    irq_gate_ctrl #(.NPER(NP)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .tmr_ovf_evt  (tmr_ovf_evt),
        .ext_edge_evt (ext_edge_evt),
        .port_chg_evt (port_chg_evt),
        .periph_req   (periph_req),
        .irq_hi       (irq_hi),
        .irq_lo       (irq_lo)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %02h expected %02h", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] r = 8'h00;
        if (a == 2'd0) r = m_ctrl;
        else if (a == 2'd1) r[2:0] = m_mode;
        else if (a == 2'd2) r[NP-1:0] = m_pen;
        else r[NP-1:0] = m_ppri;
        return r;
    endfunction

    function automatic logic [1:0] exp_irq();
        bit t = m_ctrl[2] && m_ctrl[5];
        bit x = m_ctrl[1] && m_ctrl[4];
        bit p = m_ctrl[0] && m_ctrl[3];
        bit ph = 0, pl = 0, hi = 0, lo = 0;
        for (int i = 0; i < NP; i++) begin
            if (periph_req[i] && m_pen[i]) begin
                if (!m_mode[0] || m_ppri[i]) ph = 1;
                else pl = 1;
            end
        end
        if (!m_mode[0]) begin
            hi = m_ctrl[7] && (t || x || p || (m_ctrl[6] && ph));
        end else begin
            hi = m_ctrl[7] && (x || (t && m_mode[1]) || (p && m_mode[2]) || ph);
            lo = m_ctrl[6] && ((t && !m_mode[1]) || (p && !m_mode[2]) || pl);
        end
        return {hi, lo};
    endfunction

    // drive one cycle, compare, advance model to the next edge
    task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d,
                        input bit t, input bit x, input bit p, input logic [NP-1:0] rq);
        logic [1:0] e;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d;
        tmr_ovf_evt = t; ext_edge_evt = x; port_chg_evt = p; periph_req = rq;
        #1;
        e = exp_irq();
        chk(m_mode[0] ? "R3 irq_hi" : "R2 irq_hi", {7'd0, irq_hi}, {7'd0, e[1]});
        chk(m_mode[0] ? "R4 irq_lo" : "R2 irq_lo", {7'd0, irq_lo}, {7'd0, e[0]});
        if (a == 2'd0) chk("R8 R5 R6 R7 ctrl read", rd_data, exp_read(a));
        else if (a == 2'd1) chk("R9 mode read", rd_data, exp_read(a));
        else chk("R10 peripheral read", rd_data, exp_read(a));
        if (we) begin
            case (a)
                2'd0: m_ctrl = d;
                2'd1: m_mode = d[2:0];
                2'd2: m_pen = d[NP-1:0];
                default: m_ppri = d[NP-1:0];
            endcase
        end
        if (t) m_ctrl[2] = 1'b1;
        if (x) m_ctrl[1] = 1'b1;
        if (p) m_ctrl[0] = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at every address
        for (int a = 0; a < 4; a++) step(0, 2'(a), 8'h00, 0, 0, 0, '0);
        // R5: events with everything disabled still set flags, no request
        step(0, 2'd0, 8'h00, 1, 1, 1, '0);
        step(0, 2'd0, 8'h00, 0, 0, 0, '0);
        chk("R5 flags set with enables off", rd_data, 8'h07);
        // R6: flags survive idle cycles, cleared only by a write
        step(0, 2'd0, 8'h00, 0, 0, 0, '0);
        step(1, 2'd0, 8'h00, 0, 0, 0, '0);
        step(0, 2'd0, 8'h00, 0, 0, 0, '0);
        chk("R6 flags cleared by write", rd_data, 8'h00);
        // R7: clearing write with same-cycle timer event
        step(1, 2'd0, 8'hB8, 1, 0, 0, '0);
        step(0, 2'd0, 8'h00, 0, 0, 0, '0);
        chk("R7 set beats clear", rd_data, 8'hBC);
        chk("R2 timer raises irq_hi", {7'd0, irq_hi}, 8'h01);
        // R9: upper mode bits read back as 0
        step(1, 2'd1, 8'hFF, 0, 0, 0, '0);
        step(0, 2'd1, 8'h00, 0, 0, 0, '0);
        chk("R9 mode bits", rd_data, 8'h07);
        // R10: peripheral registers are NP bits wide
        step(1, 2'd2, 8'hFF, 0, 0, 0, '0);
        step(0, 2'd2, 8'h00, 0, 0, 0, '0);
        chk("R10 enable width", rd_data, 8'h0F);
        // R4: low-priority timer routed to irq_lo
        step(1, 2'd1, 8'h01, 0, 0, 0, '0);
        step(1, 2'd0, 8'h64, 0, 0, 0, '0);
        step(0, 2'd0, 8'h00, 0, 0, 0, '0);
        chk("R4 timer low priority", {6'd0, irq_hi, irq_lo}, 8'h01);
        // random mix of writes, events and requests
        for (int n = 0; n < 6000; n++) begin
            bit we = ($urandom % 3) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [7:0] d = 8'($urandom);
            if (a == 2'd0 && ($urandom % 2) == 0) d[7:6] = 2'b11;
            step(we, a, d, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 8) == 0, NP'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule